// File: doc/BRIEF.md
# Delay-Slot Fetch Sequencer

This block chooses the fetch address for a five-stage in-order pipeline: fetch and decode, register read, ALU, memory and writeback. Each cycle the decoder reports the class of the instruction at the current fetch address. The block then advances the program counter, or starts a redirect whose length depends on the point in the pipeline where the new address becomes known. It also raises a kill flag that turns the instruction fetched in that cycle into a bubble.

An immediate jump has its target at decode. A register jump waits until its operand has been read. A conditional branch has no prediction and waits for the taken flag from the ALU stage. The first instruction after any jump or branch is a delay slot and always executes. While the block waits for a late target, the program counter stays on the fall-through address and the slots fetched there are killed.

An interrupt request works like a jump with no delay slot. The request stays pending until the instruction at fetch is neither a jump, a branch nor a multiply or divide, and no redirect is in progress. When it is accepted, the instruction at fetch is killed and its address is kept as the return address. The interrupt vector is then fetched. A global stall freezes the whole sequence.

Top module: `fetch_seq`

## Requirements
- R1: While reset is asserted and after it is released, `pc` equals the parameter RESET_VEC, `kill` is 0, `ret_addr` is 0 and no interrupt is pending.
- R2: With class code 0 (plain, including memory accesses), 4 (multiply/divide) or any of 5 to 7 at fetch, and no interrupt accepted, the next unstalled cycle fetches `pc`+1 with `kill` 0.
- R3: Class 1 (immediate jump) at address A: the next cycle fetches A+1 live (the delay slot), and the cycle after that fetches the `dec_target` value seen at decode.
- R4: Class 2 (register jump) at A: A+1 is fetched live, then A+2 with `kill` 1, then the value `reg_target` held during the A+1 cycle.
- R5: Class 3 (conditional branch) at A with `alu_taken` 1 during the A+2 cycle: A+1 is fetched live, then A+2 with `kill` 1 for two cycles, then the `dec_target` value seen at decode.
- R6: Class 3 at A with `alu_taken` 0 during the A+2 cycle: A+1 is fetched live, then A+2 killed once, then A+2 again live, after which fetch is sequential.
- R7: An accepted interrupt sets `kill` in the cycle of acceptance (address A). The next cycle keeps `pc` at A with `kill` 1 and stores A in `ret_addr`. The following cycle fetches IRQ_VEC.
- R8: An interrupt request is not accepted while the class at fetch is 1, 2, 3 or 4, or during any delay slot or killed slot. It stays pending and is accepted in the first unstalled eligible cycle.
- R9: While `stall` is 1, `pc`, `ret_addr`, the redirect progress and `kill` keep their values, except that `kill` is 0 in an eligible cycle. An interrupt request raised during a stall is kept.
- R10: The class reported during a delay slot or a killed slot has no effect on the fetch sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze the sequencer this cycle |
| dec_class | input | 3 | Class of the instruction at `pc` |
| dec_target | input | AW | Immediate target of the instruction at `pc` |
| reg_target | input | AW | Register operand, read in the register-read stage |
| alu_taken | input | 1 | Branch outcome from the ALU stage |
| irq_req | input | 1 | Interrupt request |
| pc | output | AW | Fetch address |
| kill | output | 1 | Turn the instruction fetched this cycle into a bubble |
| ret_addr | output | AW | Saved interrupt return address |

## Verification
The assertions assume that `reg_target` is valid in the delay-slot cycle of a register jump, and that `alu_taken` is valid in the first killed cycle after a branch's delay slot. They also assume that the inputs describe the instruction at the current `pc` and are not held stable across a stall. The bench derives class and target from `pc` through a fixed program function. It drives the register operand, the taken flag, interrupt pulses and stalls from a pseudo-random sequence. A behavioural queue model samples all inputs in the same cycles that the rules above name. Because the program function is hashed from the address, redirect classes fall into delay slots and killed slots, and interrupts land on blocking instructions, without any special stimulus.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam logic [2:0] CL_PLAIN  = 3'd0;
  localparam logic [2:0] CL_JIMM   = 3'd1;
  localparam logic [2:0] CL_JREG   = 3'd2;
  localparam logic [2:0] CL_BCOND  = 3'd3;
  localparam logic [2:0] CL_MULDIV = 3'd4;

  typedef enum logic [2:0] {
    ST_RUN,    // free fetch
    ST_JSLOT,  // delay slot of immediate jump
    ST_RSLOT,  // delay slot of register jump, operand read
    ST_RKILL,  // squashed slot before register target
    ST_BSLOT,  // delay slot of conditional branch
    ST_BWAIT,  // squashed slot, taken flag sampled
    ST_BKILL,  // second squashed slot of taken branch
    ST_IKILL   // squashed slot after interrupt, return saved
  } seq_state_e;

  typedef enum logic [1:0] {
    PS_HOLD,
    PS_INC,
    PS_TGT,
    PS_VEC
  } pc_src_e;

  function automatic logic cls_blocks_irq(input logic [2:0] c);
    return (c == CL_JIMM) || (c == CL_JREG) || (c == CL_BCOND) || (c == CL_MULDIV);
  endfunction

endpackage

// File: rtl/fseq_irq_gate.sv
module fseq_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic take,
  output logic pend
);

  logic pend_q;
  logic pend_d;

  assign pend = pend_q | irq_req;

  always_comb begin
    pend_d = pend & ~take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // A request that is not taken must survive to the next cycle
  p_pend_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !take) |=> pend);

endmodule

// File: rtl/fseq_ctl.sv
module fseq_ctl
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall,
  input  logic [2:0] dec_class,
  input  logic       alu_taken,
  input  logic       irq_pend,
  output pc_src_e    pc_src,
  output logic       tgt_ld_imm,
  output logic       tgt_ld_reg,
  output logic       ret_save,
  output logic       take,
  output logic       kill
);

  seq_state_e st_q;
  seq_state_e st_d;

  always_comb begin
    st_d       = st_q;
    pc_src     = PS_HOLD;
    tgt_ld_imm = 1'b0;
    tgt_ld_reg = 1'b0;
    ret_save   = 1'b0;
    take       = 1'b0;
    case (st_q)
      ST_RKILL, ST_BWAIT, ST_BKILL, ST_IKILL: kill = 1'b1;
      default:                                kill = 1'b0;
    endcase
    if (!stall) begin
      case (st_q)
        ST_RUN: begin
          if (irq_pend && !cls_blocks_irq(dec_class)) begin
            take = 1'b1;
            kill = 1'b1;
            st_d = ST_IKILL;
          end else begin
            pc_src = PS_INC;
            case (dec_class)
              CL_JIMM: begin
                tgt_ld_imm = 1'b1;
                st_d       = ST_JSLOT;
              end
              CL_JREG:  st_d = ST_RSLOT;
              CL_BCOND: begin
                tgt_ld_imm = 1'b1;
                st_d       = ST_BSLOT;
              end
              default: ;
            endcase
          end
        end
        ST_JSLOT: begin
          pc_src = PS_TGT;
          st_d   = ST_RUN;
        end
        ST_RSLOT: begin
          pc_src     = PS_INC;
          tgt_ld_reg = 1'b1;
          st_d       = ST_RKILL;
        end
        ST_RKILL: begin
          pc_src = PS_TGT;
          st_d   = ST_RUN;
        end
        ST_BSLOT: begin
          pc_src = PS_INC;
          st_d   = ST_BWAIT;
        end
        ST_BWAIT: begin
          pc_src = PS_HOLD;
          st_d   = alu_taken ? ST_BKILL : ST_RUN;
        end
        ST_BKILL: begin
          pc_src = PS_TGT;
          st_d   = ST_RUN;
        end
        ST_IKILL: begin
          pc_src   = PS_VEC;
          ret_save = 1'b1;
          st_d     = ST_RUN;
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= ST_RUN;
    else if (!stall) st_q <= st_d;
  end

  // A taken branch squashes one more slot after the wait slot
  p_taken_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BWAIT && !stall && alu_taken) |=> kill);

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc
  import fseq_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] RESET_VEC = '0,
  parameter logic [AW-1:0] IRQ_VEC   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  pc_src_e       pc_src,
  input  logic          tgt_ld_imm,
  input  logic          tgt_ld_reg,
  input  logic          ret_save,
  input  logic [AW-1:0] dec_target,
  input  logic [AW-1:0] reg_target,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ret_addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [AW-1:0] ret_q;
  logic          pc_en, tgt_en, ret_en;

  always_comb begin
    case (pc_src)
      PS_INC:  pc_d = pc_q + ONE;
      PS_TGT:  pc_d = tgt_q;
      PS_VEC:  pc_d = IRQ_VEC;
      default: pc_d = pc_q;
    endcase
    tgt_d  = tgt_ld_reg ? reg_target : dec_target;
    pc_en  = !stall;
    tgt_en = !stall && (tgt_ld_imm || tgt_ld_reg);
    ret_en = !stall && ret_save;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_VEC;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= tgt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_q <= '0;
    else if (ret_en) ret_q <= pc_q;
  end

  assign pc       = pc_q;
  assign ret_addr = ret_q;

  // Fetch address does not move across a stalled cycle
  p_stall_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> pc_q == $past(pc_q));

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fseq_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] RESET_VEC = 16'h0100,
  parameter logic [AW-1:0] IRQ_VEC   = 16'h0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [2:0]    dec_class,
  input  logic [AW-1:0] dec_target,
  input  logic [AW-1:0] reg_target,
  input  logic          alu_taken,
  input  logic          irq_req,
  output logic [AW-1:0] pc,
  output logic          kill,
  output logic [AW-1:0] ret_addr
);

  pc_src_e pc_src;
  logic    tgt_ld_imm, tgt_ld_reg, ret_save, take, pend;

  fseq_irq_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .take    (take),
    .pend    (pend)
  );

  fseq_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .dec_class  (dec_class),
    .alu_taken  (alu_taken),
    .irq_pend   (pend),
    .pc_src     (pc_src),
    .tgt_ld_imm (tgt_ld_imm),
    .tgt_ld_reg (tgt_ld_reg),
    .ret_save   (ret_save),
    .take       (take),
    .kill       (kill)
  );

  fseq_pc #(
    .AW        (AW),
    .RESET_VEC (RESET_VEC),
    .IRQ_VEC   (IRQ_VEC)
  ) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .pc_src     (pc_src),
    .tgt_ld_imm (tgt_ld_imm),
    .tgt_ld_reg (tgt_ld_reg),
    .ret_save   (ret_save),
    .dec_target (dec_target),
    .reg_target (reg_target),
    .pc         (pc),
    .ret_addr   (ret_addr)
  );

  // Vector is fetched two unstalled cycles after acceptance
  p_take_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take ##1 !stall |=> pc == IRQ_VEC);

  // Return address is the address squashed at acceptance
  p_ret_saved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take ##1 !stall |=> ret_addr == $past(pc, 2));

endmodule

// File: tb/test_fetch_seq.sv
module test_fetch_seq;

  localparam int            CLK_P     = 10;
  localparam int            AW        = 16;
  localparam logic [AW-1:0] RESET_VEC = 16'h0100;
  localparam logic [AW-1:0] IRQ_VEC   = 16'h0040;

  typedef struct packed {
    logic [15:0] pc;
    logic        kill;
    logic        free;
    logic [1:0]  act;   // 1 read operand, 2 read taken flag, 3 save return
    logic [3:0]  rq;
  } slot_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall, alu_taken, irq_req;
  logic [2:0]    dec_class;
  logic [AW-1:0] dec_target, reg_target, pc, ret_addr;
  logic          kill;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fetch_seq #(.AW(AW), .RESET_VEC(RESET_VEC), .IRQ_VEC(IRQ_VEC)) i_fetch_seq (
    .clk(clk), .rst_n(rst_n), .stall(stall), .dec_class(dec_class),
    .dec_target(dec_target), .reg_target(reg_target), .alu_taken(alu_taken),
    .irq_req(irq_req), .pc(pc), .kill(kill), .ret_addr(ret_addr)
  );

  // Program model: class and immediate target hashed from the address
  function automatic logic [2:0] cls_of(input logic [15:0] a);
    return a[2:0] ^ a[6:4] ^ a[11:9];
  endfunction
  function automatic logic [15:0] tgt_of(input logic [15:0] a);
    return a * 16'd5 + 16'h0137;
  endfunction
  function automatic bit blocking(input logic [2:0] c);
    return c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd4;
  endfunction
  function automatic string tag(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  assign dec_class  = cls_of(pc);
  assign dec_target = tgt_of(pc);

  // Reference model: a queue of upcoming fetch slots
  slot_t       q[$];
  logic [15:0] m_ret, m_btgt;
  bit          m_pend;
  logic [2:0]  s_class;
  logic [15:0] s_tgt, s_reg;
  bit          s_taken, s_irq, s_stall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      q.push_back('{pc: RESET_VEC, kill: 1'b0, free: 1'b1, act: 2'd0, rq: 4'd1});
      m_ret  = '0;
      m_pend = 1'b0;
      m_btgt = '0;
    end else if (q.size() > 0) begin
      bit    pe, acc;
      slot_t cur;
      pe  = m_pend | s_irq;
      acc = 1'b0;
      if (!s_stall) begin
        cur = q.pop_front();
        if (cur.act == 2'd1) begin
          q.push_back('{pc: cur.pc + 16'd1, kill: 1'b1, free: 1'b0, act: 2'd0, rq: 4'd4});
          q.push_back('{pc: s_reg, kill: 1'b0, free: 1'b1, act: 2'd0, rq: 4'd4});
        end else if (cur.act == 2'd2) begin
          if (s_taken) begin
            q.push_back('{pc: cur.pc, kill: 1'b1, free: 1'b0, act: 2'd0, rq: 4'd5});
            q.push_back('{pc: m_btgt, kill: 1'b0, free: 1'b1, act: 2'd0, rq: 4'd5});
          end else begin
            q.push_back('{pc: cur.pc, kill: 1'b0, free: 1'b1, act: 2'd0, rq: 4'd6});
          end
        end else if (cur.act == 2'd3) begin
          m_ret = cur.pc;
        end
        if (cur.free) begin
          if (pe && !blocking(s_class)) begin
            acc = 1'b1;
            q.push_back('{pc: cur.pc, kill: 1'b1, free: 1'b0, act: 2'd3, rq: 4'd7});
            q.push_back('{pc: IRQ_VEC, kill: 1'b0, free: 1'b1, act: 2'd0, rq: 4'd7});
          end else begin
            case (s_class)
              3'd1: begin
                q.push_back('{pc: cur.pc + 16'd1, kill: 1'b0, free: 1'b0, act: 2'd0, rq: 4'd3});
                q.push_back('{pc: s_tgt, kill: 1'b0, free: 1'b1, act: 2'd0, rq: 4'd3});
              end
              3'd2: q.push_back('{pc: cur.pc + 16'd1, kill: 1'b0, free: 1'b0, act: 2'd1, rq: 4'd4});
              3'd3: begin
                m_btgt = s_tgt;
                q.push_back('{pc: cur.pc + 16'd1, kill: 1'b0, free: 1'b0, act: 2'd0, rq: 4'd5});
                q.push_back('{pc: cur.pc + 16'd2, kill: 1'b1, free: 1'b0, act: 2'd2, rq: 4'd5});
              end
              default: q.push_back('{pc: cur.pc + 16'd1, kill: 1'b0, free: 1'b1, act: 2'd0, rq: 4'd2});
            endcase
          end
        end
      end
      m_pend = pe && !acc;
    end
  end

  task automatic chk(input bit ok, input string tg, input string what, input int act_v, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, act_v, exp_v);
    end
  endtask

  // Inputs change just after the rising edge; sample and compare on the falling edge
  always @(negedge clk) begin
    s_class = dec_class;
    s_tgt   = dec_target;
    s_reg   = reg_target;
    s_taken = alu_taken;
    s_irq   = irq_req;
    s_stall = stall;
    if (q.size() > 0 && !done) begin
      slot_t h;
      bit    ek;
      string tg;
      h  = q[0];
      ek = h.free ? (!s_stall && (m_pend || s_irq) && !blocking(s_class)) : h.kill;
      if (!rst_n)                                  tg = tag(1);
      else if (s_stall)                            tg = tag(9);
      else if (h.free && ek)                       tg = tag(7);
      else if (h.free && (m_pend || s_irq))        tg = tag(8);
      else if (!h.free && s_class inside {3'd1, 3'd2, 3'd3}) tg = tag(10);
      else                                         tg = tag(int'(h.rq));
      chk(pc == h.pc, tg, "pc", int'(pc), int'(h.pc));
      chk(kill == ek, tg, "kill", int'(kill), int'(ek));
      chk(ret_addr == m_ret, tg, "ret_addr", int'(ret_addr), int'(m_ret));
    end
  end

  logic [31:0] rng = 32'h1d2c3b4a;
  task automatic step(input int irq_thr, input int stall_thr);
    @(posedge clk);
    #1;
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    alu_taken  = rng[0];
    reg_target = rng[31:16];
    irq_req    = int'(rng[11:4]) < irq_thr;
    stall      = int'(rng[27:20]) < stall_thr;
  endtask

  initial begin
    rst_n = 1'b0; stall = 1'b0; alu_taken = 1'b0; irq_req = 1'b0; reg_target = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 1000; i++) step(0, 0);    // R2..R6, R10 without interrupts
    for (int i = 0; i < 1500; i++) step(24, 0);   // R7, R8
    for (int i = 0; i < 1500; i++) step(24, 48);  // R9 with everything mixed
    @(posedge clk);
    #1 rst_n = 1'b0; irq_req = 1'b0; stall = 1'b0;  // R1 mid-run reset
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 600; i++) step(40, 30);
    @(negedge clk);
    #1 done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

endmodule